// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block holds the interrupt state of a packet-based network controller. An 8-bit status register collects events from the transmit and receive logic. An 8-bit mask register selects which of those events drive the single interrupt line. A short queue records the numbers of packets whose transmission has completed. Software reads all of this state and writes to it over a byte-wide register bus. Reads are combinational on the address. Writes take effect at the rising clock edge on which the write strobe is sampled.

Two status bits follow hardware state as levels. The transmit-empty bit is held at 1 while the transmit queue is empty. The transmit-done bit is held at 1 while the completion queue holds an entry. Software clears status bits by writing an acknowledge value. Only a fixed subset of the bits can be cleared this way. An acknowledge that clears the transmit-done bit also removes the oldest entry from the completion queue, so that software can walk the queue one entry per acknowledge.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status register reads 0x04, the mask reads 0x00, the interrupt output is low and the completion head reads 0x80.
- R2: Address 1 is the mask register and can be read and written. The interrupt output is high exactly when the bitwise AND of status and mask is non-zero.
- R3: A 1 on an event input bit sets the matching status bit at the next clock edge. The bit stays set until an acknowledge clears it.
- R4: A write to address 0 is the acknowledge. It clears only those status bits that are 1 in both the written byte and 0xD6 (bits 7, 6, 4, 2, 1). Bits 5, 3 and 0 are never cleared by it.
- R5: While the transmit-empty input is high, status bit 2 (0x04) is 1 after every clock edge. While that input is low, an acknowledge of bit 2 clears the bit.
- R6: While the completion queue holds at least one entry, status bit 1 (0x02) is 1.
- R7: An acknowledge with bit 1 set removes the oldest completion entry. If the queue is empty, nothing is removed.
- R8: A read of address 2 returns 0x80 when the completion queue is empty. Otherwise it returns the oldest packet number, zero-extended. Entries leave the queue in the order they arrived.
- R9: The completion queue holds DEPTH entries (4 by default). A push that arrives when the queue is full, and the same cycle holds no pop, is dropped. The queue contents do not change.
- R10: If an event and an acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R11: Writes to address 2 or address 3 change no state. A read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address (0 status/ack, 1 mask, 2 completion head, 3 unused) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| evt_set | input | 8 | Per-bit status set pulses from the datapaths |
| tx_empty | input | 1 | High while the transmit queue is empty |
| done_push | input | 1 | Push a completed packet number into the completion queue |
| done_pkt | input | PKT_W | Packet number to push |
| irq | output | 1 | Interrupt line |

## Verification
The bench uses the default parameters: a completion queue depth of 4 and 6-bit packet numbers. With a depth of 4, random pushes often fill the queue, so dropped pushes and pushes that coincide with a pop occur many times in each run. With 6-bit packet numbers, every valid head value stays clear of the 0x80 empty code. Directed steps cover the fixed clearable subset, set-beats-clear and popping an empty queue. These steps run alongside random traffic in which acknowledges, events and queue pushes collide in the same cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int STS_W = 8;
    localparam logic [STS_W-1:0] ACK_CLEARABLE = 8'hD6;
    localparam int BIT_TX_EMPTY = 2;
    localparam int BIT_TX_DONE  = 1;
    localparam logic [7:0] HEAD_EMPTY_CODE = 8'h80;
    localparam logic [7:0] STS_RESET = 8'h04;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_HEAD   = 2'd2,
        REG_SPARE  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_done_fifo.sv
module irq_done_fifo #(
    parameter int DEPTH = 4,
    parameter int PKT_W = 6,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PKT_W-1:0] push_pkt,
    input  logic             pop,
    output logic [PKT_W-1:0] head,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_d
);
    typedef struct packed {
        logic [DEPTH-1:0][PKT_W-1:0] mem;
        logic [PTR_W-1:0]            rd_ptr;
        logic [PTR_W-1:0]            wr_ptr;
        logic [CNT_W-1:0]            cnt;
    } fifo_state_t;

    fifo_state_t st_q, st_d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    logic             pop_eff;
    logic             push_ok;
    logic [CNT_W-1:0] cnt_after_pop;

    always_comb begin
        st_d          = st_q;
        pop_eff       = pop && (st_q.cnt != '0);
        cnt_after_pop = st_q.cnt - CNT_W'(pop_eff);
        push_ok       = push && (cnt_after_pop < CNT_W'(DEPTH));
        if (pop_eff) begin
            st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        end
        if (push_ok) begin
            st_d.mem[st_q.wr_ptr] = push_pkt;
            st_d.wr_ptr           = ptr_inc(st_q.wr_ptr);
        end
        st_d.cnt = cnt_after_pop + CNT_W'(push_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head    = st_q.mem[st_q.rd_ptr];
    assign count_q = st_q.cnt;
    assign count_d = st_d.cnt;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] evt_set,
    input  logic [STS_W-1:0] ack_bits,
    input  logic             tx_empty,
    input  logic             done_pending,
    input  logic             mask_we,
    input  logic [STS_W-1:0] mask_wdata,
    output logic [STS_W-1:0] status_q,
    output logic [STS_W-1:0] mask_q,
    output logic             irq
);
    typedef struct packed {
        logic [STS_W-1:0] status;
        logic [STS_W-1:0] mask;
    } sts_state_t;

    sts_state_t r_q, r_d;
    logic [STS_W-1:0] clr_bits;
    logic [STS_W-1:0] level_bits;

    always_comb begin
        r_d        = r_q;
        clr_bits   = ack_bits & ACK_CLEARABLE;
        level_bits = '0;
        level_bits[BIT_TX_EMPTY] = tx_empty;
        level_bits[BIT_TX_DONE]  = done_pending;
        // Events and levels are ORed in after the clear, so a set wins.
        r_d.status = (r_q.status & ~clr_bits) | evt_set | level_bits;
        if (mask_we) begin
            r_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.status <= STS_RESET;
            r_q.mask   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign status_q = r_q.status;
    assign mask_q   = r_q.mask;
    assign irq      = |(r_q.status & r_q.mask);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PKT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [7:0]       evt_set,
    input  logic             tx_empty,
    input  logic             done_push,
    input  logic [PKT_W-1:0] done_pkt,
    output logic             irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             ack_we;
    logic             mask_we;
    logic [7:0]       ack_bits;
    logic             pop_req;
    logic [PKT_W-1:0] head_pkt;
    logic [CNT_W-1:0] done_cnt;
    logic [CNT_W-1:0] done_cnt_d;
    logic [7:0]       status_q;
    logic [7:0]       mask_q;

    assign ack_we   = bus_wr && (bus_addr == REG_STATUS);
    assign mask_we  = bus_wr && (bus_addr == REG_MASK);
    assign ack_bits = ack_we ? bus_wdata : 8'h00;
    assign pop_req  = ack_we && bus_wdata[BIT_TX_DONE];

    irq_done_fifo #(.DEPTH(DEPTH), .PKT_W(PKT_W)) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (done_push),
        .push_pkt (done_pkt),
        .pop      (pop_req),
        .head     (head_pkt),
        .count_q  (done_cnt),
        .count_d  (done_cnt_d)
    );

    irq_status_reg sts_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_set      (evt_set),
        .ack_bits     (ack_bits),
        .tx_empty     (tx_empty),
        .done_pending (done_cnt_d != '0),
        .mask_we      (mask_we),
        .mask_wdata   (bus_wdata),
        .status_q     (status_q),
        .mask_q       (mask_q),
        .irq          (irq)
    );

    always_comb begin
        unique case (bus_addr)
            REG_STATUS: bus_rdata = status_q;
            REG_MASK:   bus_rdata = mask_q;
            REG_HEAD:   bus_rdata = (done_cnt == '0) ? HEAD_EMPTY_CODE : 8'(head_pkt);
            default:    bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       evt_set,
    input logic             tx_empty,
    input logic [7:0]       status,
    input logic [7:0]       mask,
    input logic [CNT_W-1:0] cnt
);
    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((status & $past(evt_set)) == $past(evt_set))); // R3
    AST_NO_ACK_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd0) |=> ((status & $past(status)) == $past(status))); // R3
    AST_ACK_SPARES_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> ((status & $past(status) & 8'h29) == ($past(status) & 8'h29))); // R4
    AST_TXE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |=> status[2]); // R5
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> (mask == $past(bus_wdata))); // R2
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd1) |=> $stable(mask)); // R11
    AST_DONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> status[1]); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH)); // R9
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_set   (evt_set),
    .tx_empty  (tx_empty),
    .status    (status_q),
    .mask      (mask_q),
    .cnt       (done_cnt)
);

// File: tb/irq_status_ctrl_tb_top.sv
`timescale 1ns/100ps
module irq_status_ctrl_tb_top;
    localparam int DEPTH = 4;
    localparam int PKT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [7:0]       bus_wdata = 8'h00;
    logic [7:0]       bus_rdata;
    logic [7:0]       evt_set = 8'h00;
    logic             tx_empty = 1'b1;
    logic             done_push = 1'b0;
    logic [PKT_W-1:0] done_pkt = '0;
    logic             irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [7:0]       m_sts;
    logic [7:0]       m_mask;
    logic [PKT_W-1:0] m_q[$];

    always #2 clk = ~clk;

    irq_status_ctrl #(.DEPTH(DEPTH), .PKT_W(PKT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
        .tx_empty(tx_empty), .done_push(done_push), .done_pkt(done_pkt), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_head();
        if (m_q.size() == 0) return 8'h80;
        return 8'(m_q[0]);
    endfunction

    task automatic read_all(input string req);
        bus_addr = 2'd0; #0.2; check({req, "/R3 status"}, bus_rdata, m_sts);
        bus_addr = 2'd1; #0.2; check({req, "/R2 mask"}, bus_rdata, m_mask);
        bus_addr = 2'd2; #0.2; check({req, "/R8 head"}, bus_rdata, exp_head());
        bus_addr = 2'd3; #0.2; check("R11 spare read", bus_rdata, 8'h00);
        check("R2 irq", {7'd0, irq}, {7'd0, |(m_sts & m_mask)});
    endtask

    // Drive one cycle, advance the model at the edge, then check every port.
    task automatic step(input string req, input logic we, input logic [1:0] a,
                        input logic [7:0] d, input logic [7:0] ev, input logic te,
                        input logic pu, input logic [PKT_W-1:0] pk);
        logic ack;
        logic [7:0] clr;
        @(negedge clk);
        bus_wr = we; bus_addr = a; bus_wdata = d; evt_set = ev;
        tx_empty = te; done_push = pu; done_pkt = pk;
        @(posedge clk);
        ack = we && (a == 2'd0);
        clr = ack ? (d & 8'hD6) : 8'h00;
        if (ack && d[1] && m_q.size() > 0) void'(m_q.pop_front());
        if (pu && m_q.size() < DEPTH) m_q.push_back(pk);
        m_sts = (m_sts & ~clr) | ev | {5'd0, te, (m_q.size() != 0), 1'b0};
        if (we && a == 2'd1) m_mask = d;
        #1;
        bus_wr = 1'b0; evt_set = 8'h00; done_push = 1'b0;
        read_all(req);
    endtask

    initial begin
        m_sts = 8'h04; m_mask = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        bus_addr = 2'd0; #0.2; check("R1 status", bus_rdata, 8'h04);
        bus_addr = 2'd1; #0.2; check("R1 mask", bus_rdata, 8'h00);
        bus_addr = 2'd2; #0.2; check("R1 head", bus_rdata, 8'h80);
        check("R1 irq", {7'd0, irq}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R2: mask selects the transmit-empty bit
        step("R2", 1, 2'd1, 8'h04, 0, 1, 0, 0);
        check("R2 irq high", {7'd0, irq}, 8'h01);
        step("R2", 1, 2'd1, 8'h00, 0, 1, 0, 0);
        check("R2 irq low", {7'd0, irq}, 8'h00);

        // R3/R4: events on 7,6,5,3,0 then full acknowledge
        step("R3", 0, 2'd0, 0, 8'hE9, 1, 0, 0);
        check("R3 set", bus_rdata, 8'h00);
        bus_addr = 2'd0; #0.2; check("R3 status", bus_rdata, 8'hED);
        step("R4", 1, 2'd0, 8'hFF, 0, 1, 0, 0);
        bus_addr = 2'd0; #0.2; check("R4 fixed bits kept", bus_rdata, 8'h2D);
        // R5: tx_empty low lets the ack clear bit 2
        step("R5", 1, 2'd0, 8'h04, 0, 0, 0, 0);
        bus_addr = 2'd0; #0.2; check("R5 cleared", bus_rdata, 8'h29);

        // R6/R9: five pushes into a depth-4 queue
        for (int i = 1; i <= 5; i++) step("R9", 0, 2'd0, 0, 0, 0, 1, PKT_W'(i));
        bus_addr = 2'd2; #0.2; check("R9 head after overflow", bus_rdata, 8'h01);
        bus_addr = 2'd0; #0.2; check("R6 done bit", bus_rdata & 8'h02, 8'h02);
        // R7/R8: pop in order, then pop empty
        for (int i = 1; i <= 4; i++) begin
            bus_addr = 2'd2; #0.2; check("R8 order", bus_rdata, 8'(i));
            step("R7", 1, 2'd0, 8'h02, 0, 0, 0, 0);
        end
        bus_addr = 2'd2; #0.2; check("R7 empty", bus_rdata, 8'h80);
        bus_addr = 2'd0; #0.2; check("R6 done clear", bus_rdata & 8'h02, 8'h00);
        step("R7", 1, 2'd0, 8'h02, 0, 0, 0, 0);
        bus_addr = 2'd2; #0.2; check("R7 pop empty", bus_rdata, 8'h80);

        // R10: set and clear on bit 6 together
        step("R10", 1, 2'd0, 8'h40, 8'h40, 0, 0, 0);
        bus_addr = 2'd0; #0.2; check("R10 set wins", bus_rdata & 8'h40, 8'h40);

        // R11: writes to head and spare addresses
        step("R11", 1, 2'd2, 8'hFF, 0, 0, 0, 0);
        step("R11", 1, 2'd3, 8'hFF, 0, 0, 0, 0);
        bus_addr = 2'd0; #0.2; check("R11 status untouched", bus_rdata, 8'h69);

        // Random traffic
        void'($urandom(32'h1bad5eed));
        for (int n = 0; n < 3000; n++) begin
            logic we;
            logic [7:0] ev;
            we = ($urandom % 3) == 0;
            ev = 8'($urandom & $urandom & $urandom);
            step("RND", we, 2'($urandom), 8'($urandom), ev, 1'($urandom),
                 ($urandom % 3) == 0, PKT_W'($urandom));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule